// File: doc/BRIEF.md
# Tone Steering and Guard-Time Validator

This block sits behind a tone-pair decoder. It receives the decoder's early-steering level, which says a valid pair is present, together with the 4-bit code of that pair. It decides whether the pair has lasted long enough to count as a character. A digital run counter replaces the usual analog timing network. The counter measures how long the early-steering level has disagreed with the current character state. When the disagreement lasts for the programmed present guard, the character is accepted. When it lasts for the programmed absent guard, the character is ended. Any reversal of the level before the count completes restarts the count. Short tone bursts are therefore rejected, and short dropouts inside a character are bridged.

When a character is accepted, the code is captured in a receive register and the steering output goes high. After a fixed settling delay, a data-valid flag rises. This flag doubles as the status bit. When interrupt mode is enabled, an active-low interrupt asserts together with the flag. The interrupt is cleared by a read strobe or by the end of the character. All pins are plain level or strobe signals. The read strobe is accepted in any cycle and is never back-pressured; the receive data is always presented on its port.

Top module: `tsv_steer`

## Requirements
- R1: After reset, `steer_o` and `dv_flag` are 0, `irq_n` is 1 and `rx_data` is 0.
- R2: `steer_o` rises after the clock edge that samples `tone_early` high for the N-th consecutive time, where N is `present_guard`. A value of 0 acts as 1. A burst shorter than N edges never raises `steer_o` and never loads `rx_data`.
- R3: A reversal of `tone_early` before a guard count completes restarts that count. This holds both while qualifying a tone and while qualifying a pause.
- R4: `rx_data` is loaded from `tone_code` at the acceptance edge only. Later changes of `tone_code` do not alter `rx_data` until the next acceptance.
- R5: Once accepted, `steer_o` stays high. It falls after the edge that samples `tone_early` low for the M-th consecutive time, where M is `absent_guard`. A value of 0 acts as 1.
- R6: A dropout shorter than M edges keeps `steer_o` and `dv_flag` high. It does not reload `rx_data` when the tone returns, and it does not raise a new interrupt.
- R7: `dv_flag` rises exactly SETTLE_CYC edges after the acceptance edge, provided the character is still held. It falls on the same edge as `steer_o`.
- R8: With `irq_en` high, `irq_n` goes low on the edge where `dv_flag` rises. It returns high after an edge that samples `rd_stb` high, or when the character ends.
- R9: With `irq_en` low, `irq_n` is 1 after every edge.
- R10: `rd_stb` has no effect on `rx_data`, `steer_o` or `dv_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tone_early | input | 1 | Early-steering level from the tone decoder |
| tone_code | input | 4 | Code of the detected tone pair |
| present_guard | input | CNT_W (16) | Tone-present guard time in cycles |
| absent_guard | input | CNT_W (16) | Tone-absent guard time in cycles |
| irq_en | input | 1 | Interrupt mode enable |
| rd_stb | input | 1 | Receive register read strobe, clears the interrupt |
| steer_o | output | 1 | Steering output, high while a character is held |
| rx_data | output | 4 | Receive data register |
| dv_flag | output | 1 | Delayed data-valid flag and status bit |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench sweeps present guards 1 to 4 and absent guards 1 to 3. For each pair it uses every burst length from a single cycle up to past the settling point. It also runs each release to completion.

- A design with an off-by-one in the guard compare would accept a burst one edge short or one edge late.
- A design that ignores reversals would accumulate interrupted bursts into a false character.
- A design that relatches on a dropout would take the code that is present when the tone returns.
- A design that does not clear the flag at release would leave a stale status behind.

Separate runs cover interrupt clearing by a read, masking by the mode input, and zero-valued guards.

// File: rtl/tsv_pkg.sv
package tsv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_QUAL = 2'd1,
    ST_HELD = 2'd2,
    ST_DROP = 2'd3
  } steer_state_e;

  localparam int unsigned DEF_CODE_W = 4;
  localparam int unsigned DEF_CNT_W  = 16;
  localparam int unsigned DEF_SETTLE = 4;

endpackage

// File: rtl/tsv_guard.sv
module tsv_guard #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             level,
  input  logic             held,
  input  logic [CNT_W-1:0] present_cfg,
  input  logic [CNT_W-1:0] absent_cfg,
  output logic             hit
);
  localparam int unsigned EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] run_q;
  logic [CNT_W-1:0] cfg_sel;
  logic [EXT_W-1:0] limit;
  logic [EXT_W-1:0] run_next;
  logic             differ;

  assign differ   = (level != held);
  assign cfg_sel  = held ? absent_cfg : present_cfg;
  assign limit    = (cfg_sel == '0) ? EXT_W'(1) : {1'b0, cfg_sel};
  assign run_next = {1'b0, run_q} + EXT_W'(1);
  assign hit      = differ && (run_next >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (!differ || hit) begin
      run_q <= '0;
    end else begin
      run_q <= run_next[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/tsv_settle.sv
module tsv_settle #(
  parameter int unsigned SETTLE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic rel_i,
  output logic flag,
  output logic fire
);
  localparam int unsigned SW = $clog2(SETTLE_CYC + 1);

  logic [SW-1:0] left_q;

  assign fire = (left_q == SW'(1)) && !rel_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q <= '0;
      flag   <= 1'b0;
    end else if (rel_i) begin
      left_q <= '0;
      flag   <= 1'b0;
    end else if (accept) begin
      left_q <= SW'(SETTLE_CYC);
      flag   <= 1'b0;
    end else if (left_q != '0) begin
      left_q <= left_q - SW'(1);
      if (fire) flag <= 1'b1;
    end
  end
endmodule

// File: rtl/tsv_irq.sv
module tsv_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic fire,
  input  logic rd_stb,
  input  logic rel_i,
  output logic irq_n
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (!enable) begin
      pend_q <= 1'b0;
    end else if (fire) begin
      pend_q <= 1'b1;
    end else if (rd_stb || rel_i) begin
      pend_q <= 1'b0;
    end
  end

  assign irq_n = ~pend_q;
endmodule

// File: rtl/tsv_steer.sv
module tsv_steer
  import tsv_pkg::*;
#(
  parameter int unsigned CODE_W     = DEF_CODE_W,
  parameter int unsigned CNT_W      = DEF_CNT_W,
  parameter int unsigned SETTLE_CYC = DEF_SETTLE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tone_early,
  input  logic [CODE_W-1:0] tone_code,
  input  logic [CNT_W-1:0]  present_guard,
  input  logic [CNT_W-1:0]  absent_guard,
  input  logic              irq_en,
  input  logic              rd_stb,
  output logic              steer_o,
  output logic [CODE_W-1:0] rx_data,
  output logic              dv_flag,
  output logic              irq_n
);
  steer_state_e      st_q, st_d;
  logic              char_on;
  logic              hit;
  logic              accept;
  logic              rel;
  logic              fire;
  logic [CODE_W-1:0] code_q;

  assign char_on = (st_q == ST_HELD) || (st_q == ST_DROP);
  assign accept  = hit && !char_on;
  assign rel     = hit && char_on;

  tsv_guard #(.CNT_W(CNT_W)) u_guard (
    .clk         (clk),
    .rst_n       (rst_n),
    .level       (tone_early),
    .held        (char_on),
    .present_cfg (present_guard),
    .absent_cfg  (absent_guard),
    .hit         (hit)
  );

  always_comb begin
    if (hit) begin
      st_d = char_on ? ST_IDLE : ST_HELD;
    end else if (char_on) begin
      st_d = tone_early ? ST_HELD : ST_DROP;
    end else begin
      st_d = tone_early ? ST_QUAL : ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      code_q <= '0;
    end else begin
      st_q <= st_d;
      if (accept) code_q <= tone_code;
    end
  end

  tsv_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept),
    .rel_i  (rel),
    .flag   (dv_flag),
    .fire   (fire)
  );

  tsv_irq u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (irq_en),
    .fire   (fire),
    .rd_stb (rd_stb),
    .rel_i  (rel),
    .irq_n  (irq_n)
  );

  assign steer_o = char_on;
  assign rx_data = code_q;
endmodule

// File: rtl/tsv_steer_chk.sv
module tsv_steer_chk #(
  parameter int unsigned CODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tone_early,
  input logic              irq_en,
  input logic              rd_stb,
  input logic              steer_o,
  input logic [CODE_W-1:0] rx_data,
  input logic              dv_flag,
  input logic              irq_n
);
  AST_ACCEPT_NEEDS_TONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(steer_o) |-> $past(tone_early)); // R2
  AST_RELEASE_NEEDS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(steer_o) |-> !$past(tone_early)); // R5
  AST_CODE_ONLY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(steer_o) |-> $stable(rx_data)); // R4
  AST_FLAG_INSIDE_STEER: assert property (@(posedge clk) disable iff (!rst_n)
    dv_flag |-> steer_o); // R7
  AST_FLAG_AFTER_STEER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dv_flag) |-> $past(steer_o)); // R7
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> dv_flag); // R8
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |=> irq_n); // R9
  AST_READ_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && steer_o |=> $stable(rx_data)); // R10
endmodule

bind tsv_steer tsv_steer_chk #(.CODE_W(CODE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tone_early (tone_early),
  .irq_en     (irq_en),
  .rd_stb     (rd_stb),
  .steer_o    (steer_o),
  .rx_data    (rx_data),
  .dv_flag    (dv_flag),
  .irq_n      (irq_n)
);

// File: tb/test_tsv_steer.sv
module test_tsv_steer;
  localparam int CLK_PERIOD = 10;
  localparam int CW  = 8;
  localparam int SET = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          tone_early;
  logic [3:0]    tone_code;
  logic [CW-1:0] present_guard;
  logic [CW-1:0] absent_guard;
  logic          irq_en;
  logic          rd_stb;
  logic          steer_o;
  logic [3:0]    rx_data;
  logic          dv_flag;
  logic          irq_n;

  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;
  logic [3:0] exp_code;

  always #(CLK_PERIOD/2) clk = ~clk;

  tsv_steer #(.CODE_W(4), .CNT_W(CW), .SETTLE_CYC(SET)) i_tsv_steer (
    .clk(clk), .rst_n(rst_n), .tone_early(tone_early), .tone_code(tone_code),
    .present_guard(present_guard), .absent_guard(absent_guard),
    .irq_en(irq_en), .rd_stb(rd_stb), .steer_o(steer_o), .rx_data(rx_data),
    .dv_flag(dv_flag), .irq_n(irq_n)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    tone_early = 1'b0;
    repeat (n) tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tone_early = 1'b0; tone_code = 4'h0;
    present_guard = '0; absent_guard = '0; irq_en = 1'b0; rd_stb = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk(int'(steer_o), 0, "R1 steer");
    chk(int'(dv_flag), 0, "R1 flag");
    chk(int'(irq_n),   1, "R1 irq");
    chk(int'(rx_data), 0, "R1 data");

    // zero guards behave as one cycle (R2, R5)
    tone_code = 4'h5; tone_early = 1'b1;
    tick();
    chk(int'(steer_o), 1, "R2 zero guard accept");
    chk(int'(rx_data), 5, "R4 zero guard code");
    tone_early = 1'b0;
    tick();
    chk(int'(steer_o), 0, "R5 zero guard release");
    exp_code = 4'h5;

    // sweep of guards and burst lengths
    irq_en = 1'b1;
    for (int p = 1; p <= 4; p++) begin
      for (int a = 1; a <= 3; a++) begin
        for (int l = 1; l <= p + SET + 1; l++) begin
          logic [3:0] code;
          bit acc;
          present_guard = CW'(p);
          absent_guard  = CW'(a);
          idle(a + 2);
          code = 4'((p * 5 + a * 3 + l) % 16);
          acc  = (l >= p);
          tone_code  = code;
          tone_early = 1'b1;
          for (int n = 1; n <= l; n++) begin
            tick();
            chk(int'(steer_o), int'(n >= p), "R2 accept timing");
            chk(int'(dv_flag), int'(n >= p + SET), "R7 flag timing");
            chk(int'(irq_n), int'(!(n >= p + SET)), "R8 irq timing");
            if (n == p) tone_code = code ^ 4'h9;
          end
          if (acc) exp_code = code;
          chk(int'(rx_data), int'(exp_code), "R4 latched code");
          tone_code  = ~code;
          tone_early = 1'b0;
          for (int m = 1; m <= a + 1; m++) begin
            tick();
            chk(int'(steer_o), int'(acc && m < a), "R5 release timing");
            chk(int'(dv_flag), int'(acc && m < a && l + m >= p + SET), "R7 flag release");
            chk(int'(rx_data), int'(exp_code), "R4 code held");
          end
        end
      end
    end

    // R3: interrupted bursts never accumulate
    present_guard = CW'(4); absent_guard = CW'(2);
    idle(4);
    tone_code = 4'hE;
    for (int r = 0; r < 3; r++) begin
      tone_early = 1'b1;
      repeat (3) begin tick(); chk(int'(steer_o), 0, "R3 restart present"); end
      tone_early = 1'b0;
      tick();
      chk(int'(steer_o), 0, "R3 restart present");
    end
    chk(int'(rx_data), int'(exp_code), "R3 no latch");

    // R6 dropout, R8 read clear, R10 read effect, R3 on pause count
    present_guard = CW'(2); absent_guard = CW'(3);
    idle(4);
    tone_code = 4'hA; tone_early = 1'b1;
    repeat (2 + SET) tick();
    chk(int'(dv_flag), 1, "R7 flag up");
    chk(int'(irq_n),   0, "R8 irq up");
    tone_code = 4'h3; tone_early = 1'b0;
    repeat (2) begin
      tick();
      chk(int'(steer_o), 1, "R6 dropout steer");
      chk(int'(dv_flag), 1, "R6 dropout flag");
    end
    tone_early = 1'b1;
    repeat (2) begin tick(); chk(int'(rx_data), 10, "R6 no relatch"); end
    rd_stb = 1'b1;
    tick();
    rd_stb = 1'b0;
    chk(int'(irq_n),   1, "R8 read clears irq");
    chk(int'(dv_flag), 1, "R10 flag kept");
    chk(int'(steer_o), 1, "R10 steer kept");
    chk(int'(rx_data), 10, "R10 data kept");
    tone_early = 1'b0;
    repeat (2) tick();
    tone_early = 1'b1;
    tick();
    tone_early = 1'b0;
    repeat (2) tick();
    chk(int'(steer_o), 1, "R3 restart absent");
    chk(int'(irq_n),   1, "R6 no new irq");
    tick();
    chk(int'(steer_o), 0, "R5 full release");
    chk(int'(dv_flag), 0, "R7 flag falls");

    // R8: release clears a pending interrupt
    present_guard = CW'(1); absent_guard = CW'(1);
    idle(3);
    tone_early = 1'b1;
    repeat (1 + SET) tick();
    chk(int'(irq_n), 0, "R8 irq pending");
    tone_early = 1'b0;
    tick();
    chk(int'(irq_n), 1, "R8 release clears irq");

    // R9: interrupt masked
    irq_en = 1'b0;
    idle(3);
    tone_early = 1'b1;
    for (int k = 1; k <= SET + 2; k++) begin
      tick();
      chk(int'(irq_n), 1, "R9 masked irq");
    end
    chk(int'(dv_flag), 1, "R9 flag still set");
    idle(3);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule